// File: doc/BRIEF.md
# SD Card SPI Command Framer

This block sends one command to a memory card running in SPI mode and returns the card's one-byte reply. A controller places a 6-bit command index and a 32-bit argument on the inputs and pulses `start`. The block then runs the whole exchange over a byte-wide SPI master. Each byte slot is opened with a one-cycle request strobe and closed by the master's completion strobe, which also returns the byte clocked in from the card.

First the block waits for the card to become ready. It keeps reading bytes until one of them is 0xFF. This wait is bounded by a budget of 10 ms ticks from an external strobe. If the budget runs out, the command is dropped. The block then sends the six-byte frame, skips one extra byte after the stop command, and polls for the reply a bounded number of times. When the exchange ends, `done` pulses for one cycle. At the same time the reply byte and two flags are updated: a busy timeout and a missing response. All three hold until the next completion.

Top module: `sd_cmd_framer`

## Requirements
- R1: After reset `done` and `spi_go` are 0, `resp` is 0xFF, and `busy_timeout` and `no_resp` are 0.
- R2: After an accepted `start`, receive slots are issued one at a time until the card returns 0xFF. The frame starts only after that byte. The number of ready-wait slots is the number of non-0xFF bytes plus one.
- R3: The first frame byte is 0x40 OR the command index. The next four bytes are the argument, bits 31:24 first and bits 7:0 last.
- R4: The sixth frame byte is 0x95 for command 0, 0x87 for command 8 and 0xFF for every other command, whatever the argument.
- R5: After command 12 exactly one extra received byte is discarded before response polling starts. It is never taken as the response, even when its bit 7 is clear.
- R6: Response polling stops at the first byte with bit 7 clear. That byte becomes `resp`, with `no_resp` = 0.
- R7: At most 10 response bytes are read. If all 10 have bit 7 set, `no_resp` = 1 and `resp` is the tenth byte. Nine such bytes followed by a valid one is still a success.
- R8: The ready budget is loaded with 50 at start and drops by one on each `tick_10ms` while non-zero. If a non-0xFF byte arrives while the budget is zero, the command ends with `busy_timeout` = 1, `resp` = 0xFF and no frame byte sent. The check uses the budget value from before a tick in the same cycle. A 0xFF byte counts as ready even when the budget is zero.
- R9: Every slot that is not a frame byte (ready wait, discarded byte, polls) transmits 0xFF.
- R10: `done` is a one-cycle pulse. `resp`, `busy_timeout` and `no_resp` change only with it. A `start` while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| tick_10ms | input | 1 | One-cycle strobe every 10 ms |
| spi_go | output | 1 | One-cycle request to run one byte slot |
| spi_tx | output | 8 | Byte to send in the requested slot |
| spi_done | input | 1 | Byte slot finished, `spi_rx` valid |
| spi_rx | input | 8 | Byte received in the finished slot |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | Response byte of the last command |
| busy_timeout | output | 1 | Last command was dropped waiting for ready |
| no_resp | output | 1 | Last command got no byte with bit 7 clear |

## Verification
Two of this block's functions can act on the same clock edge: the tick that empties the ready budget and the arrival of a busy byte from the card. The bench lets the card model raise `tick_10ms` exactly on the edges where it returns ready-wait bytes. With 50 such coincident ticks and a card that never frees up, a design that uses the budget from before the tick reads exactly 51 slots before timing out. A design that uses the value after the tick stops at 50. A second run returns 0xFF on slot 51, when the budget is already zero, and must still proceed to the frame.

// File: rtl/sd_cmd_pkg.sv
// Shared definitions for the SD SPI command framer.
// Assumes command indices are 6 bits and frames are six bytes long.
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READY,
        ST_SEND,
        ST_STUFF,
        ST_POLL
    } fsm_t;

    localparam int          FRAME_BYTES = 6;
    localparam logic [5:0]  CMD_RESET   = 6'd0;
    localparam logic [5:0]  CMD_IFCOND  = 6'd8;
    localparam logic [5:0]  CMD_STOP    = 6'd12;
    localparam logic [7:0]  FILL_BYTE   = 8'hFF;

    // Fixed check byte sent as the last byte of a frame
    function automatic logic [7:0] crc_const(input logic [5:0] idx);
        if (idx == CMD_RESET)       return 8'h95;
        else if (idx == CMD_IFCOND) return 8'h87;
        else                        return 8'hFF;
    endfunction

endpackage

// File: rtl/sd_ready_timer.sv
// Ready-wait budget: a down-counter that is loaded when a command starts
// and is decremented by an external tick. It stops at zero.
// Assumes tick is a one-cycle strobe.
module sd_ready_timer #(
    parameter int LOAD = 50,
    localparam int W   = $clog2(LOAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    logic [W-1:0] cnt;

    // Load on start, count down on tick while non-zero
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (load)                  cnt <= W'(LOAD);
        else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
    end

    // The budget is spent when the count is zero (value before this edge)
    always_comb expired = (cnt == '0);

endmodule

// File: rtl/sd_frame_mux.sv
// Selects one byte of the six-byte command frame.
// Slot 0 is the start/index byte, slots 1..4 are the argument from the
// most significant byte down, and slot 5 is the fixed check byte.
module sd_frame_mux
    import sd_cmd_pkg::*;
#(
    parameter int SEL_W = $clog2(FRAME_BYTES)
) (
    input  logic [5:0]       cmd_idx,
    input  logic [31:0]      cmd_arg,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       frame_byte
);
    logic [7:0] arg_bytes [4];

    // Split the argument into bytes, most significant first
    for (genvar g = 0; g < 4; g++) begin : g_arg
        assign arg_bytes[g] = cmd_arg[31 - 8*g -: 8];
    end

    // Pick the byte for the requested slot
    always_comb begin
        if (sel == '0)
            frame_byte = {2'b01, cmd_idx};
        else if (sel < SEL_W'(FRAME_BYTES - 1))
            frame_byte = arg_bytes[2'(sel - 1'b1)];
        else
            frame_byte = crc_const(cmd_idx);
    end

endmodule

// File: rtl/sd_cmd_framer.sv
// Sequences one card command over a byte-level SPI master. The steps are:
// ready wait, six-byte frame, one discarded byte after the stop command,
// and bounded response polling.
// Assumes the master answers each spi_go with exactly one spi_done and
// never raises spi_done unrequested.
module sd_cmd_framer
    import sd_cmd_pkg::*;
#(
    parameter int READY_TICKS = 50,
    parameter int POLL_LIMIT  = 10,
    localparam int POLL_W     = $clog2(POLL_LIMIT + 1),
    localparam int SEL_W      = $clog2(FRAME_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  cmd_idx,
    input  logic [31:0] cmd_arg,
    input  logic        tick_10ms,
    output logic        spi_go,
    output logic [7:0]  spi_tx,
    input  logic        spi_done,
    input  logic [7:0]  spi_rx,
    output logic        done,
    output logic [7:0]  resp,
    output logic        busy_timeout,
    output logic        no_resp
);
    fsm_t              state;
    logic              pend;
    logic [5:0]        idx_q;
    logic [31:0]       arg_q;
    logic [SEL_W-1:0]  sel;
    logic [POLL_W-1:0] polls;
    logic [7:0]        frame_byte;
    logic              expired;
    logic              accept;

    always_comb accept = start && (state == ST_IDLE);

    sd_ready_timer #(.LOAD(READY_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .tick    (tick_10ms),
        .expired (expired)
    );

    sd_frame_mux #(.SEL_W(SEL_W)) u_mux (
        .cmd_idx    (idx_q),
        .cmd_arg    (arg_q),
        .sel        (sel),
        .frame_byte (frame_byte)
    );

    // Command sequencer: one slot request at a time, decision per byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            pend         <= 1'b0;
            idx_q        <= '0;
            arg_q        <= '0;
            sel          <= '0;
            polls        <= '0;
            spi_go       <= 1'b0;
            spi_tx       <= FILL_BYTE;
            done         <= 1'b0;
            resp         <= 8'hFF;
            busy_timeout <= 1'b0;
            no_resp      <= 1'b0;
        end else begin
            spi_go <= 1'b0;
            done   <= 1'b0;
            if (state == ST_IDLE) begin
                if (accept) begin
                    idx_q <= cmd_idx;
                    arg_q <= cmd_arg;
                    pend  <= 1'b0;
                    state <= ST_READY;
                end
            end else if (!pend) begin
                spi_go <= 1'b1;
                spi_tx <= (state == ST_SEND) ? frame_byte : FILL_BYTE;
                pend   <= 1'b1;
            end else if (spi_done) begin
                pend <= 1'b0;
                case (state)
                    ST_READY: begin
                        if (spi_rx == 8'hFF) begin
                            sel   <= '0;
                            state <= ST_SEND;
                        end else if (expired) begin
                            resp         <= 8'hFF;
                            busy_timeout <= 1'b1;
                            no_resp      <= 1'b0;
                            done         <= 1'b1;
                            state        <= ST_IDLE;
                        end
                    end
                    ST_SEND: begin
                        if (sel == SEL_W'(FRAME_BYTES - 1)) begin
                            polls <= '0;
                            state <= (idx_q == CMD_STOP) ? ST_STUFF : ST_POLL;
                        end else begin
                            sel <= sel + 1'b1;
                        end
                    end
                    ST_STUFF: begin
                        state <= ST_POLL;
                    end
                    ST_POLL: begin
                        if (!spi_rx[7] || polls == POLL_W'(POLL_LIMIT - 1)) begin
                            resp         <= spi_rx;
                            busy_timeout <= 1'b0;
                            no_resp      <= spi_rx[7];
                            done         <= 1'b1;
                            state        <= ST_IDLE;
                        end else begin
                            polls <= polls + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sd_cmd_framer_chk.sv
// Port-level checker for the command framer, attached with bind.
module sd_cmd_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_go,
    input logic [7:0] spi_tx,
    input logic       spi_done,
    input logic       done,
    input logic [7:0] resp,
    input logic       busy_timeout,
    input logic       no_resp
);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results change only together with done
    a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(resp) && $stable(busy_timeout) && $stable(no_resp)));

    // R2: slot requests are single-cycle, never back to back
    a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |=> !spi_go);

    // R8: a busy timeout reports 0xFF and never also a missing response
    a_r8_timeout_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_timeout) |-> (resp == 8'hFF && !no_resp));

    // R7: a missing response carries a byte with bit 7 set
    a_r7_no_resp_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_resp) |-> resp[7]);

    // R6: a successful reply has bit 7 clear
    a_r6_valid_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_resp && !busy_timeout) |-> !resp[7]);

endmodule

bind sd_cmd_framer sd_cmd_framer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_go       (spi_go),
    .spi_tx       (spi_tx),
    .spi_done     (spi_done),
    .done         (done),
    .resp         (resp),
    .busy_timeout (busy_timeout),
    .no_resp      (no_resp)
);

// File: tb/sd_cmd_framer_test.sv
module sd_cmd_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        tick_10ms;
    logic        spi_go;
    logic [7:0]  spi_tx;
    logic        spi_done;
    logic [7:0]  spi_rx;
    logic        done;
    logic [7:0]  resp;
    logic        busy_timeout;
    logic        no_resp;

    always #2.5 clk = ~clk;

    sd_cmd_framer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .tick_10ms(tick_10ms), .spi_go(spi_go),
        .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx), .done(done),
        .resp(resp), .busy_timeout(busy_timeout), .no_resp(no_resp)
    );

    int errors = 0;
    int checks = 0;

    // card model configuration (written by tasks)
    logic       mclr = 1'b0;
    int         c_busy, c_kbad, c_tmode, c_tper, c_tlim;
    logic [7:0] c_rv, c_sv;
    logic       c_stop;

    // card model state
    int         phase, rdy_seen, fi, pj, lat, tcnt, tleft, bad_fill;
    logic       mpend;
    logic [7:0] sent;
    logic [7:0] frm [6];

    // Card and SPI master model: answers each request after a random latency
    always @(posedge clk) begin
        spi_done  <= 1'b0;
        tick_10ms <= 1'b0;
        if (mclr) begin
            phase <= 0; rdy_seen <= 0; fi <= 0; pj <= 0; mpend <= 1'b0;
            tcnt <= 0; tleft <= c_tlim; bad_fill <= 0; spi_rx <= 8'hFF;
        end else begin
            if (c_tmode == 0) begin
                if (tcnt >= c_tper - 1) begin tcnt <= 0; tick_10ms <= 1'b1; end
                else tcnt <= tcnt + 1;
            end
            if (spi_go) begin
                sent  <= spi_tx;
                lat   <= 1 + int'($urandom % 4);
                mpend <= 1'b1;
            end else if (mpend) begin
                if (lat > 1) lat <= lat - 1;
                else begin
                    mpend    <= 1'b0;
                    spi_done <= 1'b1;
                    if (phase != 1 && sent != 8'hFF) bad_fill <= bad_fill + 1;
                    case (phase)
                        0: begin
                            if (c_tmode == 1 && tleft > 0) begin
                                tick_10ms <= 1'b1; tleft <= tleft - 1;
                            end
                            if (rdy_seen < c_busy) spi_rx <= 8'h00;
                            else begin spi_rx <= 8'hFF; phase <= 1; end
                            rdy_seen <= rdy_seen + 1;
                        end
                        1: begin
                            frm[fi] <= sent;
                            spi_rx  <= 8'hFF;
                            fi      <= fi + 1;
                            if (fi == 5) phase <= c_stop ? 2 : 3;
                        end
                        2: begin spi_rx <= c_sv; phase <= 3; end
                        default: begin
                            spi_rx <= (pj < c_kbad) ? (8'h80 | 8'(pj)) : c_rv;
                            pj     <= pj + 1;
                        end
                    endcase
                end
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_crc(input logic [5:0] idx);
        if (idx == 6'd0) return 8'h95;
        if (idx == 6'd8) return 8'h87;
        return 8'hFF;
    endfunction

    // Run one command. exp_to: expect a busy timeout. exp_rdy: expected
    // ready-wait slot count (negative means do not check).
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input int nbusy, input int kbad,
                           input logic [7:0] rv, input logic [7:0] sv,
                           input int tmode, input int tper, input int tlim,
                           input bit exp_to, input int exp_rdy, input bit inject);
        int n;
        logic [7:0] a_resp;
        logic a_to, a_nr;
        c_busy = nbusy; c_kbad = kbad; c_rv = rv; c_sv = sv;
        c_tmode = tmode; c_tper = tper; c_tlim = tlim; c_stop = (idx == 6'd12);
        @(negedge clk); mclr = 1'b1;
        @(negedge clk); mclr = 1'b0;
        cmd_idx = idx; cmd_arg = arg; start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (inject && n == 15) begin
                start = 1'b1; cmd_idx = 6'd33; cmd_arg = 32'hDEADBEEF;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) begin
            check("R10", "watchdog done", 0, 1);
            return;
        end
        a_resp = resp; a_to = busy_timeout; a_nr = no_resp;
        @(negedge clk);
        check("R10", "done single cycle", done, 0);
        if (exp_rdy >= 0) check("R2", "ready slots", rdy_seen, exp_rdy);
        check("R9", "fill bytes", bad_fill, 0);
        if (exp_to) begin
            check("R8", "busy_timeout", a_to, 1);
            check("R8", "timeout resp", a_resp, 8'hFF);
            check("R8", "no frame sent", fi, 0);
        end else begin
            check("R8", "busy_timeout", a_to, 0);
            check("R3", "first byte", frm[0], 8'h40 | {2'b00, idx});
            check("R3", "argument", {frm[1], frm[2], frm[3], frm[4]}, arg);
            check("R4", "check byte", frm[5], exp_crc(idx));
            check("R7", "poll count", pj, (kbad >= 10) ? 10 : kbad + 1);
            if (kbad >= 10) begin
                check("R7", "no_resp", a_nr, 1);
                check("R7", "last byte", a_resp, 8'h89);
            end else begin
                check("R6", "no_resp", a_nr, 0);
                check("R6", "resp", a_resp, rv);
            end
            if (idx == 6'd12) check("R5", "stuff consumed", phase, 3);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        c_busy = 0; c_kbad = 0; c_tmode = 2; c_tper = 1; c_tlim = 0;
        c_rv = 8'h00; c_sv = 8'h00; c_stop = 1'b0;
        repeat (4) @(negedge clk);
        mclr = 1'b1;
        @(negedge clk);
        mclr = 1'b0;
        // R1: reset values
        check("R1", "done", done, 0);
        check("R1", "spi_go", spi_go, 0);
        check("R1", "resp", resp, 8'hFF);
        check("R1", "flags", {busy_timeout, no_resp}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: fixed check bytes
        run_cmd(6'd0, 32'h0, 0, 0, 8'h01, 8'h00, 2, 1, 0, 0, 1, 0);
        run_cmd(6'd8, 32'h000001AA, 2, 1, 8'h01, 8'h00, 2, 1, 0, 0, 3, 0);
        run_cmd(6'd0, 32'h12345678, 0, 0, 8'h05, 8'h00, 2, 1, 0, 0, 1, 0);
        // R5: stop command, discarded byte looks valid but must be skipped
        run_cmd(6'd12, 32'h0, 1, 0, 8'h00, 8'h05, 2, 1, 0, 0, 2, 0);
        run_cmd(6'd12, 32'h0, 0, 3, 8'h7F, 8'h3C, 2, 1, 0, 0, 1, 0);
        // R7: nine busy polls then valid, and ten busy polls
        run_cmd(6'd17, 32'hA5A55A5A, 0, 9, 8'h00, 8'h00, 2, 1, 0, 0, 1, 0);
        run_cmd(6'd24, 32'h00000200, 0, 10, 8'h00, 8'h00, 2, 1, 0, 0, 1, 0);
        // R8: periodic ticks, card never ready
        run_cmd(6'd55, 32'h0, 1000000, 0, 8'h00, 8'h00, 0, 5, 0, 1, -1, 0);
        // R8: ticks coincide with every ready byte, card never ready
        run_cmd(6'd41, 32'h40000000, 1000000, 0, 8'h00, 8'h00, 1, 1, 50, 1, 51, 0);
        // R8: ready byte arrives when budget already zero
        run_cmd(6'd41, 32'h40000000, 50, 0, 8'h00, 8'h00, 1, 1, 50, 0, 51, 0);
        // R10: start during a command is ignored
        run_cmd(6'd9, 32'hCAFEF00D, 3, 2, 8'h00, 8'h00, 2, 1, 0, 0, 4, 1);
        // R10: outputs hold after completion
        begin
            logic [7:0] held;
            held = resp;
            cmd_idx = 6'd1; cmd_arg = 32'hFFFFFFFF;
            repeat (20) @(negedge clk);
            check("R10", "resp held", resp, held);
            check("R10", "done idle", done, 0);
        end
        // R3, R6: random commands
        for (int i = 0; i < 20; i++) begin
            logic [5:0]  ri;
            logic [31:0] ra;
            int          rb, rk;
            logic [7:0]  rr;
            ri = 6'($urandom);
            if (ri == 6'd12) ri = 6'd13;
            ra = $urandom;
            rb = int'($urandom % 6);
            rk = int'($urandom % 10);
            rr = 8'($urandom) & 8'h7F;
            run_cmd(ri, ra, rb, rk, rr, 8'h00, 0, 40, 0, 0, rb + 1, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Global watchdog
    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule